// File: doc/BRIEF.md
# I2C Serial EEPROM Slave

A synthesizable two-wire bus slave that fronts a 2048-byte internal storage array. The array stands in for nonvolatile memory. The block samples SCL and SDA with a fast system clock. It detects bus START and STOP conditions and decodes an address header that holds a device type, the three high address bits and a direction bit. It drives SDA only through an open-drain pull-low enable. The bus line seen on `sda_i` is the wired result of the master and of that enable.

Writes are gathered into a 16-slot page buffer. At STOP they are committed by a timed internal write cycle. During that cycle the slave does not react to the bus, so a master can keep sending headers until one is acknowledged. Reads come from an internal address counter. The counter supports current-address, random and sequential reads, and sequential reads run across the whole array.

The block also emits a single-cycle pulse each time it acknowledges its own header. A neighbouring watchdog can use that pulse as its restart event.

Top module: `i2c_ee_slave`

## Requirements
- R1: A header whose upper nibble is 4'b1010 is acknowledged (SDA pulled low in the ninth clock). Any other upper nibble returns the slave to idle, and SDA is never pulled low for the rest of that transaction.
- R2: `addr_ack_o` is high for exactly one system clock for each acknowledged header, and at no other time.
- R3: In a write header, bits [3:1] are address bits 10..8 and bit 0 = 0 selects write. The next byte sets address bits 7..0. The slave acknowledges every byte of a write.
- R4: Successive write data bytes advance only address bits 3..0, which wrap inside the 16-byte page. A 17th byte therefore replaces the first one.
- R5: A STOP after at least one data byte starts an internal write cycle of WR_CYCLES system clocks. The buffered bytes become readable when that cycle ends.
- R6: While the write cycle runs, START conditions are ignored and no header is acknowledged. The first header after the cycle ends is acknowledged.
- R7: A read header (bit 0 = 1; its address bits are not used) returns data starting at the internal counter. The counter holds one more than the last address accessed.
- R8: A write header plus address byte, followed by a repeated START and a read header, returns the byte at that address.
- R9: During a read, each transmitted byte advances all 11 address bits. Address 2047 is followed by 0.
- R10: Read data goes out MSB first. SDA changes only after SCL falls, never while SCL is high. After a master non-acknowledge, the slave releases SDA and stays silent until STOP.
- R11: While `rst_ni` is low, `sda_oe_o` and `addr_ack_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| addr_ack_o | output | 1 | One-cycle pulse when the own header is acknowledged |

## Verification
A change on SCL reaches the state machine after two synchronizer stages. `sda_oe_o` then changes on the third system clock after an SCL fall. The bench holds each SCL phase for eight clocks and samples acknowledge and data bits in the middle of the high phase, well after any such change. The write cycle ends WR_CYCLES clocks after STOP is recognised. The bench measures this by polling with headers and checks both that the first acknowledge arrives no earlier than that and that at least one poll was refused. A sweep of page, byte, wrapping sequential and non-acknowledged reads is compared with a byte model that the bench updates from the written addresses.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_ADDR,
    ST_WDATA,
    ST_ACK,
    ST_RDATA,
    ST_RACK,
    ST_WAIT
  } ee_state_e;

  localparam logic [3:0] EE_DEV_TYPE = 4'b1010;
endpackage

// File: rtl/i2c_ee_sync.sv
module i2c_ee_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d, scl_s, sda_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_d  <= scl_s;
      sda_d  <= sda_s;
    end
  end

  assign scl_s      = scl_ff[STAGES-1];
  assign sda_s      = sda_ff[STAGES-1];
  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_d;
  assign scl_fall_o = ~scl_s & scl_d;
  // data edge while clock stays high
  assign start_o    = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_o     = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_ee_store.sv
module i2c_ee_store #(
  parameter int ADDR_W    = 11,
  parameter int PAGE_W    = 4,
  parameter int WR_CYCLES = 50000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic              launch_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic              busy_o
);
  localparam int PAGE_N = 1 << PAGE_W;
  localparam int PG_W   = ADDR_W - PAGE_W;
  localparam int CNT_W  = $clog2(WR_CYCLES + 1);

  logic [7:0]        mem    [2**ADDR_W];
  logic [7:0]        slot_d [PAGE_N];
  logic [PAGE_N-1:0] slot_v;
  logic [PG_W-1:0]   page_q;
  logic              busy_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              commit;

  assign commit = busy_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_v <= '0;
      page_q <= '0;
      for (int i = 0; i < PAGE_N; i++) slot_d[i] <= '0;
    end else if (commit) begin
      slot_v <= '0;
    end else if (wr_en_i) begin
      page_q                            <= wr_addr_i[ADDR_W-1:PAGE_W];
      slot_d[wr_addr_i[PAGE_W-1:0]]     <= wr_data_i;
      slot_v[wr_addr_i[PAGE_W-1:0]]     <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (launch_i && |slot_v) begin
        busy_q <= 1'b1;
        cnt_q  <= CNT_W'(WR_CYCLES - 1);
      end
    end else if (cnt_q == '0) begin
      busy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (commit)
      for (int i = 0; i < PAGE_N; i++)
        if (slot_v[i]) mem[{page_q, PAGE_W'(i)}] <= slot_d[i];
  end

  assign rd_data_o = mem[rd_addr_i];
  assign busy_o    = busy_q;

  a_r6_no_fill_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> !wr_en_i);
  a_r5_cycle_runs_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q != '0) |=> busy_q);
endmodule

// File: rtl/i2c_ee_slave.sv
module i2c_ee_slave
  import i2c_ee_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int PAGE_W      = 4,
  parameter int WR_CYCLES   = 50000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o,
  output logic addr_ack_o
);
  localparam int HI_W = ADDR_W - 8;

  logic sda_s, scl_rise, scl_fall, start, stop, busy;
  logic [7:0] rd_data;

  ee_state_e         state, after;
  logic [3:0]        bit_cnt;
  logic [7:0]        sh, tx, wr_data;
  logic [ADDR_W-1:0] addr_q, wr_addr;
  logic              oe, ack_pulse, m_ack, wr_en;

  i2c_ee_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start), .stop_o(stop)
  );

  i2c_ee_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)) u_store (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .launch_i(stop), .rd_addr_i(addr_q), .rd_data_o(rd_data), .busy_o(busy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state     <= ST_IDLE;
      after     <= ST_IDLE;
      bit_cnt   <= '0;
      sh        <= '0;
      tx        <= '0;
      addr_q    <= '0;
      oe        <= 1'b0;
      ack_pulse <= 1'b0;
      m_ack     <= 1'b0;
      wr_en     <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
    end else begin
      ack_pulse <= 1'b0;
      wr_en     <= 1'b0;
      if (start && !busy) begin
        state   <= ST_DEV;
        bit_cnt <= '0;
        oe      <= 1'b0;
      end else if (stop) begin
        state <= ST_IDLE;
        oe    <= 1'b0;
      end else begin
        case (state)
          ST_DEV, ST_ADDR, ST_WDATA: begin
            if (scl_rise) begin
              sh      <= {sh[6:0], sda_s};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall && bit_cnt == 4'd8) begin
              bit_cnt <= '0;
              if (state == ST_DEV) begin
                if (sh[7:4] == EE_DEV_TYPE) begin
                  oe        <= 1'b1;
                  ack_pulse <= 1'b1;
                  state     <= ST_ACK;
                  if (sh[0]) after <= ST_RDATA;
                  else begin
                    after                <= ST_ADDR;
                    addr_q[ADDR_W-1:8]   <= sh[HI_W:1];
                  end
                end else begin
                  state <= ST_IDLE;
                end
              end else if (state == ST_ADDR) begin
                addr_q[7:0] <= sh;
                oe          <= 1'b1;
                state       <= ST_ACK;
                after       <= ST_WDATA;
              end else begin
                wr_en                <= 1'b1;
                wr_addr              <= addr_q;
                wr_data              <= sh;
                addr_q[PAGE_W-1:0]   <= addr_q[PAGE_W-1:0] + 1'b1;  // page-local wrap
                oe                   <= 1'b1;
                state                <= ST_ACK;
                after                <= ST_WDATA;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              state   <= after;
              bit_cnt <= '0;
              if (after == ST_RDATA) begin
                tx <= rd_data;
                oe <= ~rd_data[7];
              end else begin
                oe <= 1'b0;
              end
            end
          end
          ST_RDATA: begin
            if (scl_rise) begin
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall) begin
              if (bit_cnt == 4'd8) begin
                oe     <= 1'b0;
                state  <= ST_RACK;
                addr_q <= addr_q + 1'b1;  // full-array wrap
              end else begin
                oe <= ~tx[3'd7 - bit_cnt[2:0]];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              m_ack <= ~sda_s;
            end else if (scl_fall) begin
              if (m_ack) begin
                tx      <= rd_data;
                oe      <= ~rd_data[7];
                bit_cnt <= '0;
                state   <= ST_RDATA;
              end else begin
                state <= ST_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o   = oe;
  assign addr_ack_o = ack_pulse;

  a_r2_ack_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_ack_o |=> !addr_ack_o);
  a_r1_ack_pulls_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_ack_o |-> sda_oe_o);
  a_r6_silent_in_write_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !sda_oe_o);
  a_r10_drive_after_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(scl_fall) && !$past(start) && !$past(stop)) |-> $stable(sda_oe_o));
endmodule

// File: tb/i2c_ee_slave_tb.sv
module i2c_ee_slave_tb;
  localparam int WRC = 300;
  localparam int Q   = 8;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
  logic sda_oe, addr_ack, sda_line;
  int   total = 0, bad = 0, cyc = 0;
  int   ack_pulses = 0, ack_hi = 0, hdr_acks = 0, glitches = 0, oe_cnt = 0;
  bit   mon_en = 0, done = 0, ack_prev = 0, scl_prev = 1, sda_prev = 1;
  logic [7:0] model [2048];

  assign sda_line = sda_m & ~sda_oe;
  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  i2c_ee_slave #(.WR_CYCLES(WRC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .addr_ack_o(addr_ack)
  );

  always @(negedge clk) begin
    if (addr_ack) ack_hi++;
    if (addr_ack && !ack_prev) ack_pulses++;
    ack_prev = addr_ack;
    if (mon_en && scl && scl_prev && sda_line != sda_prev) glitches++;
    scl_prev = scl;
    sda_prev = sda_line;
    if (sda_oe) oe_cnt++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] hdr(input int a, input bit rw);
    return {4'hA, 3'(a >> 8), rw};
  endfunction

  function automatic logic [7:0] pat(input int s);
    return 8'((s * 37 + 11) ^ (s >> 3));
  endfunction

  task automatic qw();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1; qw(); scl = 1; qw(); sda_m = 0; qw(); scl = 0; qw();
  endtask

  task automatic bus_stop();
    sda_m = 0; qw(); scl = 1; qw(); sda_m = 1; qw();
  endtask

  task automatic put_bit(input bit b);
    sda_m = b; qw(); scl = 1; qw(); qw(); scl = 0; qw();
  endtask

  task automatic get_bit(output bit b);
    sda_m = 1; qw(); scl = 1; qw(); b = sda_line; qw(); scl = 0; qw();
  endtask

  task automatic wr_byte(input logic [7:0] d, output bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    ack = !b;
  endtask

  task automatic send_hdr(input logic [7:0] h, output bit ack);
    wr_byte(h, ack);
    if (ack) hdr_acks++;
  endtask

  task automatic rd_byte(input bit mack, output logic [7:0] d);
    bit b;
    mon_en = 1;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      d[i] = b;
    end
    mon_en = 0;
    put_bit(!mack);
  endtask

  task automatic poll_ready();
    bit a;
    int t0, nacks;
    t0 = cyc; nacks = 0;
    for (int k = 0; k < 40; k++) begin
      bus_start();
      send_hdr(hdr(0, 0), a);
      bus_stop();
      if (a) break;
      nacks++;
    end
    check(nacks >= 1, "R6 polls refused during write cycle", nacks, 1);
    check((cyc - t0) >= WRC && (cyc - t0) < WRC + 800, "R5 write cycle length", cyc - t0, WRC);
  endtask

  task automatic page_write(input int base, input int n, input int seed);
    bit a;
    logic [7:0] d;
    bus_start();
    send_hdr(hdr(base, 0), a);
    check(a, "R3 write header ack", a, 1);
    wr_byte(8'(base), a);
    check(a, "R3 address byte ack", a, 1);
    for (int k = 0; k < n; k++) begin
      d = pat(seed + k);
      wr_byte(d, a);
      check(a, "R3 data byte ack", a, 1);
      model[(base & 'h7F0) | ((base + k) & 'hF)] = d;
    end
    bus_stop();
    poll_ready();
  endtask

  task automatic seq_read(input int addr, input int n, input string req);
    bit a;
    logic [7:0] d;
    int ea;
    bus_start();
    send_hdr(hdr(addr, 0), a);
    wr_byte(8'(addr), a);
    bus_start();
    send_hdr(hdr(0, 1), a);
    check(a, "R8 read header ack", a, 1);
    for (int k = 0; k < n; k++) begin
      rd_byte(k != n - 1, d);
      ea = (addr + k) & 'h7FF;
      check(d === model[ea], req, d, model[ea]);
    end
    bus_stop();
  endtask

  task automatic cur_read(input int addr, input int n, input string req);
    bit a;
    logic [7:0] d;
    int ea;
    bus_start();
    send_hdr(hdr(5 << 8, 1), a);
    check(a, "R7 current read header ack", a, 1);
    for (int k = 0; k < n; k++) begin
      rd_byte(k != n - 1, d);
      ea = (addr + k) & 'h7FF;
      check(d === model[ea], req, d, model[ea]);
    end
    bus_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit a;
    logic [7:0] d;
    int p0, o0;
    repeat (5) @(negedge clk);
    check(sda_oe == 1'b0, "R11 sda released in reset", sda_oe, 0);
    check(addr_ack == 1'b0, "R11 ack pulse low in reset", addr_ack, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);

    // full pages at the top and bottom of the array
    page_write('h7F0, 16, 1);
    page_write('h000, 16, 40);
    seq_read('h7F8, 16, "R9 sequential read wraps 2047 to 0");
    cur_read('h008, 2, "R7 current address read");

    // 17 bytes from mid-page: last one lands on the first slot
    page_write('h2A5, 17, 80);
    seq_read('h2A0, 16, "R4 page wrap overwrite");

    for (int i = 0; i < 6; i++) page_write((i * 'h155 + 3) & 'h7FF, 1, 100 + i);
    for (int i = 0; i < 6; i++) seq_read((i * 'h155 + 3) & 'h7FF, 1, "R8 random read");

    // foreign device type
    p0 = ack_pulses; o0 = oe_cnt;
    bus_start();
    wr_byte(8'hB0, a);
    check(!a, "R1 foreign header not acked", a, 0);
    wr_byte(8'h3C, a);
    bus_stop();
    check(oe_cnt == o0, "R1 line untouched after mismatch", oe_cnt - o0, 0);
    check(ack_pulses == p0, "R1 no ack pulse on mismatch", ack_pulses - p0, 0);

    // master NACK then extra clocks: slave must stay silent
    bus_start();
    send_hdr(hdr('h7FC, 0), a);
    wr_byte(8'hFC, a);
    bus_start();
    send_hdr(hdr(0, 1), a);
    rd_byte(1'b0, d);
    check(d === model['h7FC], "R10 MSB-first byte before nack", d, model['h7FC]);
    o0 = oe_cnt;
    for (int k = 0; k < 9; k++) begin
      bit b;
      get_bit(b);
    end
    check(oe_cnt == o0, "R10 silent after nack", oe_cnt - o0, 0);
    bus_stop();
    cur_read('h7FD, 1, "R10 counter advanced once after nack");

    check(glitches == 0, "R10 SDA stable while SCL high", glitches, 0);
    check(ack_hi == ack_pulses, "R2 ack pulse one cycle wide", ack_hi, ack_pulses);
    check(ack_pulses == hdr_acks, "R2 one pulse per acked header", ack_pulses, hdr_acks);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule